// File: doc/BRIEF.md
# Comma Word Aligner with Slide Counting

This block brings a 20-bit parallel receive stream into word alignment. Each word carries two 10-bit symbol lanes. The block watches the stream for the positive-running-disparity comma. Whenever that comma shows up anywhere except the first lane, it sends the deserializer a one-cycle slide request. Each request shifts the deserializer's word boundary by one bit.

Every slide is counted. Once lock is reached, the count gives the bit offset between the recovered word clock and the transmitted word boundary, in unit intervals. Higher logic multiplies it by the unit interval (0.8 ns on a gigabit link) to compensate the fixed latency of the link. A restart, or a full reset, clears the count and starts the search again from nothing. After lock, the block keeps watching, and it falls back to searching if the comma settles in the second lane.

Top module: `comma_aligner`

## Requirements
- R1: During and after reset (rst_n low, synchronous), slide_req, aligned, wrap_err and slide_cnt are all 0.
- R2: The searched comma is 10'b0101111100, written with symbol bit 9 as MSB. Lane 0 is rx_word[9:0] and lane 1 is rx_word[19:10]. The serial order is LSB first. Detection runs over a window made of the previous valid word followed by the current one, so a comma that straddles two words is still found. Only words with rx_valid high take part, so words with rx_valid low are ignored.
- R3: A comma found at any window offset other than 0, with none at offset 0, raises slide_req for exactly one cycle.
- R4: After a slide request, no window is evaluated for SETTLE_CYC clocks (default 32). Two slide requests are therefore never fewer than SETTLE_CYC cycles apart.
- R5: slide_cnt changes only when a slide is issued, and it changes in the same cycle that slide_req is high. It stays in 0..19 and equals the number of slides issued since the last reset or restart, modulo 20.
- R6: aligned rises in the cycle after the fourth consecutive evaluated window with the comma in lane 0. Windows with no comma neither count toward this nor reset the run.
- R7: The negative comma 10'b1010000011 causes neither a slide nor lock.
- R8: The twentieth slide wraps slide_cnt from 19 to 0 and sets wrap_err in that same cycle. wrap_err then stays high until reset or restart.
- R9: While aligned, four consecutive windows with the comma in lane 1 drop aligned and resume the search. slide_cnt keeps accumulating from its current value.
- R10: A restart pulse clears slide_cnt, aligned and wrap_err, and the search starts anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous restart of the alignment search |
| rx_valid | input | 1 | rx_word holds a valid word |
| rx_word | input | 20 | Raw parallel word from the deserializer |
| slide_req | output | 1 | One-cycle request to shift the word boundary by one bit |
| aligned | output | 1 | Comma is locked in lane 0 |
| slide_cnt | output | 5 | Slides issued since reset or restart, modulo 20 |
| wrap_err | output | 1 | Sticky: the slide count has wrapped |

## Verification
The twentieth slide request and the count's wrap from 19 to 0 land in the same cycle. The wrap also sets the error flag in that cycle.

To provoke this, the bench freezes its barrel-rotator deserializer model at a misaligned phase, so every slide request goes unanswered. It then counts the request pulses as they come out. On the nineteenth pulse it expects a count of 19 with no error. On the twentieth pulse it expects, in that same sampled cycle, a count of 0 with the error flag raised, and it then confirms that the flag stays high.

// File: rtl/comma_align_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and state type for the comma aligner.
// Assumes 10-bit symbols, written with bit 9 as MSB.
package comma_align_pkg;
    localparam int SYM_BITS = 10;
    localparam logic [SYM_BITS-1:0] COMMA_POS = 10'b0101111100;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_t;
endpackage

// File: rtl/comma_locate.sv
`timescale 1ns/1ps
// comma_locate: finds the positive comma in a window built from the
// previous valid word and the current one (serial order is LSB first).
// It reports whether the comma sits at offset 0 (lane 0), at offset SYM_W
// (lane 1), or at some other offset.
// Assumes that flush empties the window history: the next valid word only
// refills it and is not evaluated.
module comma_locate
    import comma_align_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 rx_valid,
    input  logic [2*SYM_W-1:0]   rx_word,
    output logic                 win_valid,
    output logic                 at_lane0,
    output logic                 at_lane1,
    output logic                 at_other
);
    localparam int WORD_W = 2 * SYM_W;
    localparam int SPAN_W = 2 * WORD_W;

    logic [WORD_W-1:0] prev_q;
    logic              prev_ok;
    logic [SPAN_W-1:0] span;
    logic [WORD_W-1:0] hit;
    logic [WORD_W-1:0] other_mask;

    // Keep the last valid word as the low half of the detection window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            prev_ok <= 1'b0;
        end else if (flush) begin
            prev_ok <= 1'b0;
        end else if (rx_valid) begin
            prev_q  <= rx_word;
            prev_ok <= 1'b1;
        end
    end

    assign span = {rx_word, prev_q};

    // One comparator for each bit offset of the window.
    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        assign hit[k] = (span[k +: SYM_W] == COMMA_POS[SYM_W-1:0]);
    end

    // Mask that keeps only the offsets other than lane 0 and lane 1.
    always_comb begin
        other_mask        = '1;
        other_mask[0]     = 1'b0;
        other_mask[SYM_W] = 1'b0;
    end

    assign win_valid = rx_valid && prev_ok && !flush;
    assign at_lane0  = hit[0];
    assign at_lane1  = hit[SYM_W];
    assign at_other  = |(hit & other_mask);
endmodule

// File: rtl/align_fsm.sv
`timescale 1ns/1ps
// align_fsm: search / settle / locked controller. It issues single-cycle
// slide requests, counts slides modulo WORD_W, and flags a wrap.
// Assumes the window flags are meaningful only when win_valid is high.
module align_fsm
    import comma_align_pkg::*;
#(
    parameter int WORD_W     = 20,
    parameter int SETTLE_CYC = 32,
    parameter int LOCK_N     = 4,
    parameter int LOSS_N     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      win_valid,
    input  logic                      at_lane0,
    input  logic                      at_lane1,
    input  logic                      at_other,
    output logic                      flush,
    output logic                      slide_req,
    output logic                      aligned,
    output logic [$clog2(WORD_W)-1:0] slide_cnt,
    output logic                      wrap_err
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam int RUN_W = $clog2((LOCK_N > LOSS_N ? LOCK_N : LOSS_N) + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WORD_W - 1);

    align_state_t     state;
    logic [SET_W-1:0] settle_q;
    logic [RUN_W-1:0] run_q;

    // The window is emptied on restart and during every settle period.
    assign flush = restart || (state == ST_SETTLE);

    // Sequencing of search, slide settling and lock tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state     <= ST_SEARCH;
            settle_q  <= '0;
            run_q     <= '0;
            slide_req <= 1'b0;
            aligned   <= 1'b0;
            slide_cnt <= '0;
            wrap_err  <= 1'b0;
        end else begin
            slide_req <= 1'b0;
            case (state)
                ST_SEARCH: begin
                    if (win_valid) begin
                        if (at_lane0) begin
                            if (run_q == RUN_W'(LOCK_N - 1)) begin
                                state   <= ST_LOCKED;
                                aligned <= 1'b1;
                                run_q   <= '0;
                            end else begin
                                run_q <= run_q + 1'b1;
                            end
                        end else if (at_lane1 || at_other) begin
                            slide_req <= 1'b1;
                            run_q     <= '0;
                            settle_q  <= '0;
                            state     <= ST_SETTLE;
                            if (slide_cnt == CNT_TOP) begin
                                slide_cnt <= '0;
                                wrap_err  <= 1'b1;
                            end else begin
                                slide_cnt <= slide_cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_q == SET_W'(SETTLE_CYC - 1)) begin
                        state <= ST_SEARCH;
                    end else begin
                        settle_q <= settle_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (win_valid) begin
                        if (at_lane0) begin
                            run_q <= '0;
                        end else if (at_lane1) begin
                            if (run_q == RUN_W'(LOSS_N - 1)) begin
                                state   <= ST_SEARCH;
                                aligned <= 1'b0;
                                run_q   <= '0;
                            end else begin
                                run_q <= run_q + 1'b1;
                            end
                        end
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end
endmodule

// File: rtl/comma_aligner.sv
`timescale 1ns/1ps
// comma_aligner: top level. It word-aligns a two-lane 10-bit symbol stream
// on the positive comma and reports the number of bit slides applied.
// Assumes that the deserializer shifts its boundary by one bit for each
// slide_req pulse.
module comma_aligner #(
    parameter int WORD_W     = 20,
    parameter int SETTLE_CYC = 32,
    parameter int LOCK_N     = 4,
    parameter int LOSS_N     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      rx_valid,
    input  logic [WORD_W-1:0]         rx_word,
    output logic                      slide_req,
    output logic                      aligned,
    output logic [$clog2(WORD_W)-1:0] slide_cnt,
    output logic                      wrap_err
);
    localparam int SYM_W = WORD_W / 2;

    logic flush, win_valid, at_lane0, at_lane1, at_other;

    comma_locate #(.SYM_W(SYM_W)) u_locate (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .win_valid (win_valid),
        .at_lane0  (at_lane0),
        .at_lane1  (at_lane1),
        .at_other  (at_other)
    );

    align_fsm #(
        .WORD_W     (WORD_W),
        .SETTLE_CYC (SETTLE_CYC),
        .LOCK_N     (LOCK_N),
        .LOSS_N     (LOSS_N)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .win_valid (win_valid),
        .at_lane0  (at_lane0),
        .at_lane1  (at_lane1),
        .at_other  (at_other),
        .flush     (flush),
        .slide_req (slide_req),
        .aligned   (aligned),
        .slide_cnt (slide_cnt),
        .wrap_err  (wrap_err)
    );
endmodule

// File: rtl/comma_aligner_chk.sv
`timescale 1ns/1ps
// comma_aligner_chk: protocol checks on the aligner ports, bound into
// comma_aligner. The settle spacing is measured with a counter rather than
// with a long delay.
module comma_aligner_chk #(
    parameter int WORD_W     = 20,
    parameter int SETTLE_CYC = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      restart,
    input logic                      slide_req,
    input logic                      aligned,
    input logic [$clog2(WORD_W)-1:0] slide_cnt,
    input logic                      wrap_err
);
    localparam int CNT_W = $clog2(WORD_W);
    logic [15:0] gap_q;

    // Cycles since the last slide request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)      gap_q <= 16'hFFFF;
        else if (slide_req)         gap_q <= 16'd1;
        else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
    end

    assert_slide_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slide_req |=> !slide_req);

    assert_settle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slide_req && !restart) |-> (gap_q >= 16'(SETTLE_CYC)));

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slide_cnt <= CNT_W'(WORD_W - 1));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slide_req |-> (slide_cnt == (($past(slide_cnt) == CNT_W'(WORD_W - 1)) ?
                                     '0 : $past(slide_cnt) + 1'b1)));

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!slide_req && !$past(restart)) |-> $stable(slide_cnt));

    assert_no_slide_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slide_req |-> !aligned);

    assert_wrap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_err && !restart) |=> wrap_err);

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!aligned && !wrap_err && slide_cnt == '0 && !slide_req));
endmodule

bind comma_aligner comma_aligner_chk #(
    .WORD_W     (WORD_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .slide_req (slide_req),
    .aligned   (aligned),
    .slide_cnt (slide_cnt),
    .wrap_err  (wrap_err)
);

// File: tb/comma_aligner_tb.sv
`timescale 1ns/1ps
// Directed bench. A barrel rotator stands in for the deserializer.
module comma_aligner_tb;
    localparam logic [19:0] PAT_PLUS  = {10'b0, 10'b0101111100};
    localparam logic [19:0] PAT_MINUS = {10'b0, 10'b1010000011};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       rx_valid = 1'b0;
    logic [19:0] rx_word = '0;
    logic       slide_req, aligned, wrap_err;
    logic [4:0] slide_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int phase_base = 0;
    bit stuck = 1'b0;
    bit stream_on = 1'b0;
    bit gap_mode = 1'b0;
    bit gap_tick = 1'b0;
    logic [19:0] pat = PAT_PLUS;
    int pulses = 0;
    int vcount = 0;
    int cyc = 0;
    int last_pulse = 0;
    int min_gap = 1000000;
    bit vnow;
    bit done = 1'b0;

    always #4 clk = ~clk;

    comma_aligner u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .slide_req (slide_req),
        .aligned   (aligned),
        .slide_cnt (slide_cnt),
        .wrap_err  (wrap_err)
    );

    function automatic logic [19:0] rot(input logic [19:0] p, input int sh);
        return (p >> sh) | (p << (20 - sh));
    endfunction

    // Rotator model: the phase advances by one on each slide pulse unless stuck.
    always @(negedge clk) begin
        gap_tick <= ~gap_tick;
        vnow = stream_on && (!gap_mode || gap_tick);
        rx_valid <= vnow;
        rx_word  <= vnow ? rot(pat, (phase_base + (stuck ? 0 : pulses)) % 20)
                         : rot(PAT_PLUS, 7);
    end

    // Count slide pulses, valid words and pulse spacing.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || restart) begin
            pulses <= 0;
            vcount <= 0;
        end else begin
            if (rx_valid) vcount <= vcount + 1;
            if (slide_req) begin
                if (pulses > 0 && (cyc - last_pulse) < min_gap) min_gap <= cyc - last_pulse;
                last_pulse <= cyc;
                pulses <= pulses + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_restart(input int base, input logic [19:0] p,
                              input bit stk, input bit gap);
        @(posedge clk); #1;
        phase_base = base; pat = p; stuck = stk; gap_mode = gap; stream_on = 1'b1;
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
    endtask

    task automatic wait_lock(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (aligned) begin got = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(slide_req == 0 && aligned == 0 && wrap_err == 0, "R1", "flags in reset",
            {slide_req, aligned, wrap_err}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(slide_cnt == 0, "R1", "count after reset", slide_cnt, 0);
        chk(aligned == 0, "R1", "aligned after reset", aligned, 0);
    endtask

    task automatic t_phase(input int p);
        bit got;
        do_restart(p, PAT_PLUS, 1'b0, 1'b0);
        wait_lock(got);
        chk(got, "R6", $sformatf("lock at phase %0d", p), got, 1);
        chk(slide_cnt == (20 - p) % 20, "R5", $sformatf("slide count at phase %0d", p),
            slide_cnt, (20 - p) % 20);
        chk(pulses == (20 - p) % 20, "R3", $sformatf("slide pulses at phase %0d", p),
            pulses, (20 - p) % 20);
        chk(wrap_err == 0, "R8", "no wrap on a normal search", wrap_err, 0);
    endtask

    task automatic t_lock_timing();
        bit got;
        do_restart(0, PAT_PLUS, 1'b0, 1'b1);
        wait_lock(got);
        chk(got && vcount == 5, "R6", "valid words until lock", vcount, 5);
        chk(pulses == 0, "R2", "invalid misaligned words ignored", pulses, 0);
        gap_mode = 1'b0;
    endtask

    task automatic t_settle();
        min_gap = 1000000;
        t_phase(1);
        chk(min_gap >= 32, "R4", "minimum slide spacing", min_gap, 32);
    endtask

    task automatic t_minus();
        do_restart(5, PAT_MINUS, 1'b0, 1'b0);
        repeat (200) @(negedge clk);
        chk(pulses == 0, "R7", "slides on negative comma", pulses, 0);
        chk(aligned == 0, "R7", "lock on negative comma", aligned, 0);
    endtask

    task automatic t_wrap();
        int n = 0;
        do_restart(5, PAT_PLUS, 1'b1, 1'b0);
        for (int i = 0; i < 2000 && n < 20; i++) begin
            @(negedge clk);
            if (slide_req) begin
                n++;
                if (n == 19) begin
                    chk(slide_cnt == 19, "R5", "count at slide 19", slide_cnt, 19);
                    chk(wrap_err == 0, "R8", "error before wrap", wrap_err, 0);
                end
                if (n == 20) begin
                    chk(slide_cnt == 0, "R8", "count wraps on slide 20", slide_cnt, 0);
                    chk(wrap_err == 1, "R8", "error with wrap", wrap_err, 1);
                end
            end
        end
        chk(n == 20, "R8", "slides observed", n, 20);
        repeat (100) @(negedge clk);
        chk(wrap_err == 1, "R8", "error stays set", wrap_err, 1);
        do_restart(0, PAT_PLUS, 1'b0, 1'b0);
        @(negedge clk);
        chk(wrap_err == 0 && slide_cnt == 0, "R10", "restart clears error and count",
            {wrap_err, slide_cnt}, 0);
    endtask

    task automatic t_loss();
        bit got;
        bit dropped = 1'b0;
        t_phase(13);
        @(posedge clk); #1;
        phase_base = 23;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!aligned) begin dropped = 1'b1; break; end
        end
        chk(dropped, "R9", "lock lost on lane 1 commas", dropped, 1);
        wait_lock(got);
        chk(got, "R9", "relock after loss", got, 1);
        chk(slide_cnt == 17, "R9", "count accumulates after loss", slide_cnt, 17);
        chk(wrap_err == 0, "R9", "no wrap after loss", wrap_err, 0);
    endtask

    task automatic t_restart_mid();
        do_restart(2, PAT_PLUS, 1'b0, 1'b0);
        for (int i = 0; i < 500 && pulses < 3; i++) @(negedge clk);
        do_restart(2, PAT_PLUS, 1'b0, 1'b0);
        @(negedge clk);
        chk(slide_cnt == 0, "R10", "count cleared mid-search", slide_cnt, 0);
        chk(aligned == 0 && slide_req == 0, "R10", "flags cleared mid-search",
            {aligned, slide_req}, 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_phase(0);
        t_phase(3);
        t_phase(11);
        t_phase(19);
        t_phase(10);
        t_lock_timing();
        t_settle();
        t_minus();
        t_wrap();
        t_loss();
        t_restart_mid();
        done = 1'b1;
        report();
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule